// File: doc/BRIEF.md
# Two-Level Page Access Permission Checker

This block decides, for one memory access at a time, whether the access may proceed, is stopped by the segment check, or is stopped by the page check. A request carries the access type (read or write), the current privilege (user or supervisor), and a flag that forces a supervisor-level check. Two more inputs drive the check: the write-protect enable, and the user and writable attribute bits of every translation level. The caller also supplies the outcome of the segment check that was already done: a fault flag and whether the segment may be written.

The attribute bits of all levels are folded into one effective user bit and one effective writable bit. The block checks the segment first and the page second. A segment fault always hides any page fault, so page attributes can never grant a right that the segment withholds. The verdict and a three-bit page-fault error vector are registered on the clock edge that follows a valid request. A one-cycle valid pulse marks the new result, and the result stays on the outputs until the next request.

Top module: `prot_gate`

## Requirements
- R1: When `reqValid` is 1 at a rising edge, `rspValid` is 1 for exactly the following cycle and `rspCode`/`rspErr` show that request's verdict. When `reqValid` is 0, `rspValid` is 0 in the next cycle and `rspCode`/`rspErr` keep their values.
- R2: A synchronous reset (`rst` = 1 at a rising edge) sets `rspValid` to 0, `rspCode` to 00 and `rspErr` to 000, even if a request is present.
- R3: `rspCode` encodes 00 = allowed, 01 = segment fault, 10 = page fault. The value 11 never appears.
- R4: Bit 0 of `entUser`/`entWrite` is the first-level entry and bit 1 is the second-level entry. A page counts as user-accessible only if every level's user bit is 1, and as writable only if every level's writable bit is 1.
- R5: A user-privilege access faults at page level if the page is not user-accessible. A user-privilege write also faults if the page is not writable. Otherwise a user read or write is allowed.
- R6: A supervisor-privilege read never produces a page fault.
- R7: A supervisor write to a page that is user-accessible but not writable is a page fault when `wpEnable` = 1, and is allowed when `wpEnable` = 0.
- R8: A write to a page that is neither user-accessible nor writable is a page fault from either privilege, whatever the value of `wpEnable`.
- R9: When `reqForceSup` = 1, the request is checked as a supervisor access even if `reqUser` = 1.
- R10: When `segFault` = 1, the verdict is 01 whatever the page attributes say, and no page fault is reported.
- R11: A write with `segWritable` = 0 gives a segment fault (01) even when every page level is writable. For reads, `segWritable` has no effect.
- R12: On a page fault, `rspErr[0]` = 1 (protection violation, never not-present), `rspErr[1]` = 1 for a write, and `rspErr[2]` = 1 when the access was checked as user privilege (0 when forced to supervisor). For any other verdict, `rspErr` = 000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | A request is present this cycle |
| reqWrite | input | 1 | 1 = write access, 0 = read access |
| reqUser | input | 1 | 1 = current privilege is user, 0 = supervisor |
| reqForceSup | input | 1 | Check this access as supervisor regardless of `reqUser` |
| wpEnable | input | 1 | Supervisor writes honour read-only user pages |
| entUser | input | LEVELS | User-accessible bit per translation level (bit 0 = first level) |
| entWrite | input | LEVELS | Writable bit per translation level (bit 0 = first level) |
| segFault | input | 1 | The earlier segment check failed |
| segWritable | input | 1 | The segment allows writes |
| rspValid | output | 1 | One-cycle pulse: a new verdict is on the outputs |
| rspCode | output | 2 | Verdict: 00 allow, 01 segment fault, 10 page fault |
| rspErr | output | 3 | Page-fault error vector {user, write, protection} |

## Verification
The bound checker watches several properties on every cycle. It checks the one-cycle request-to-valid relation and that results are held between requests. It checks that 11 never appears on `rspCode` and that the error vector stays silent outside page faults. It also checks three cross-cycle rules: a segment fault always wins, a supervisor read never page-faults, and a read-only supervisor page always refuses writes. Some behaviours depend on specific combinations of attributes and privilege, so only the bench's vector table shows them. These are the per-level AND folding, the `wpEnable` split for supervisor writes, the privilege override and its effect on the error vector's user bit, and `segWritable` having no effect on reads. The directed tests add back-to-back requests and a reset that arrives while a request is present.

// File: rtl/prot_gate_pkg.sv
package prot_gate_pkg;

  localparam int CODE_W = 2;
  localparam int ERR_W  = 3;

  // Bit positions inside the page-fault error vector
  localparam int ERR_PROT_BIT  = 0;
  localparam int ERR_WRITE_BIT = 1;
  localparam int ERR_USER_BIT  = 2;

  typedef enum logic [CODE_W-1:0] {
    RES_ALLOW = 2'b00,
    RES_SEG   = 2'b01,
    RES_PAGE  = 2'b10
  } result_e;

  // Control-to-datapath strobes
  typedef struct packed {
    logic capture;  // load the new verdict
    logic clear;    // return result registers to the reset value
  } strobe_t;

endpackage

// File: rtl/prot_gate_ctrl.sv
module prot_gate_ctrl
  import prot_gate_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    reqValid,
  output strobe_t strobes,
  output logic    rspValid
);

  always_comb begin
    strobes.clear   = rst;
    strobes.capture = reqValid & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rspValid <= 1'b0;
    end else begin
      rspValid <= reqValid;
    end
  end

endmodule

// File: rtl/prot_gate_dp.sv
module prot_gate_dp
  import prot_gate_pkg::*;
#(
  parameter int LEVELS = 2
) (
  input  logic              clk,
  input  strobe_t           strobes,
  input  logic              reqWrite,
  input  logic              reqUser,
  input  logic              reqForceSup,
  input  logic              wpEnable,
  input  logic [LEVELS-1:0] entUser,
  input  logic [LEVELS-1:0] entWrite,
  input  logic              segFault,
  input  logic              segWritable,
  output logic [CODE_W-1:0] rspCode,
  output logic [ERR_W-1:0]  rspErr
);

  // Fold attributes across the translation levels
  logic [LEVELS:0] userChain;
  logic [LEVELS:0] writeChain;

  assign userChain[0]  = 1'b1;
  assign writeChain[0] = 1'b1;

  for (genvar lvl = 0; lvl < LEVELS; lvl++) begin : g_fold
    assign userChain[lvl+1]  = userChain[lvl]  & entUser[lvl];
    assign writeChain[lvl+1] = writeChain[lvl] & entWrite[lvl];
  end

  logic effUser;
  logic effWrite;
  logic checkAsUser;
  logic segBlock;
  logic pageBlock;
  result_e nextCode;
  logic [ERR_W-1:0] nextErr;

  assign effUser     = userChain[LEVELS];
  assign effWrite    = writeChain[LEVELS];
  assign checkAsUser = reqUser & ~reqForceSup;

  always_comb begin
    segBlock = segFault | (reqWrite & ~segWritable);

    if (checkAsUser) begin
      pageBlock = ~effUser | (reqWrite & ~effWrite);
    end else begin
      pageBlock = reqWrite & ~effWrite & (~effUser | wpEnable);
    end

    if (segBlock) begin
      nextCode = RES_SEG;
    end else if (pageBlock) begin
      nextCode = RES_PAGE;
    end else begin
      nextCode = RES_ALLOW;
    end

    nextErr = '0;
    if (nextCode == RES_PAGE) begin
      nextErr[ERR_PROT_BIT]  = 1'b1;
      nextErr[ERR_WRITE_BIT] = reqWrite;
      nextErr[ERR_USER_BIT]  = checkAsUser;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      rspCode <= RES_ALLOW;
      rspErr  <= '0;
    end else if (strobes.capture) begin
      rspCode <= nextCode;
      rspErr  <= nextErr;
    end
  end

endmodule

// File: rtl/prot_gate.sv
module prot_gate
  import prot_gate_pkg::*;
#(
  parameter int LEVELS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqUser,
  input  logic              reqForceSup,
  input  logic              wpEnable,
  input  logic [LEVELS-1:0] entUser,
  input  logic [LEVELS-1:0] entWrite,
  input  logic              segFault,
  input  logic              segWritable,
  output logic              rspValid,
  output logic [1:0]        rspCode,
  output logic [2:0]        rspErr
);

  strobe_t strobes;

  prot_gate_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .strobes  (strobes),
    .rspValid (rspValid)
  );

  prot_gate_dp #(.LEVELS(LEVELS)) dp_i (
    .clk         (clk),
    .strobes     (strobes),
    .reqWrite    (reqWrite),
    .reqUser     (reqUser),
    .reqForceSup (reqForceSup),
    .wpEnable    (wpEnable),
    .entUser     (entUser),
    .entWrite    (entWrite),
    .segFault    (segFault),
    .segWritable (segWritable),
    .rspCode     (rspCode),
    .rspErr      (rspErr)
  );

endmodule

// File: rtl/prot_gate_chk.sv
module prot_gate_chk #(
  parameter int LEVELS = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic              reqWrite,
  input logic              reqUser,
  input logic              reqForceSup,
  input logic [LEVELS-1:0] entUser,
  input logic [LEVELS-1:0] entWrite,
  input logic              segFault,
  input logic              segWritable,
  input logic              rspValid,
  input logic [1:0]        rspCode,
  input logic [2:0]        rspErr
);

  // R1
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> rspValid);

  // R1
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> !rspValid);

  // R1
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> ($stable(rspCode) && $stable(rspErr)));

  // R3
  code_legal_chk: assert property (@(posedge clk) disable iff (rst)
    rspValid |-> (rspCode != 2'b11));

  // R12
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (rspValid && rspCode != 2'b10) |-> (rspErr == 3'b000));

  // R12
  err_prot_chk: assert property (@(posedge clk) disable iff (rst)
    (rspValid && rspCode == 2'b10) |-> rspErr[0]);

  // R10
  seg_first_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && segFault) |=> (rspCode == 2'b01));

  // R6
  sup_read_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !reqWrite && (!reqUser || reqForceSup) && !segFault)
      |=> (rspCode == 2'b00));

  // R8
  sup_ro_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqWrite && !segFault && segWritable && !(&entUser) && !(&entWrite))
      |=> (rspCode == 2'b10));

endmodule

bind prot_gate prot_gate_chk #(.LEVELS(LEVELS)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .reqValid    (reqValid),
  .reqWrite    (reqWrite),
  .reqUser     (reqUser),
  .reqForceSup (reqForceSup),
  .entUser     (entUser),
  .entWrite    (entWrite),
  .segFault    (segFault),
  .segWritable (segWritable),
  .rspValid    (rspValid),
  .rspCode     (rspCode),
  .rspErr      (rspErr)
);

// File: tb/prot_gate_tb_top.sv
module prot_gate_tb_top;

  typedef struct packed {
    logic       wr;
    logic       usr;
    logic       frc;
    logic       wp;
    logic [1:0] eu;
    logic [1:0] ew;
    logic       sf;
    logic       sw;
    logic [1:0] code;
    logic [2:0] err;
  } vec_t;

  localparam int NV = 18;

  // fields: wr usr frc wp eu ew sf sw | code err{user,write,prot}
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,1'b0,1'b0,2'b11,2'b00,1'b0,1'b1, 2'b00,3'b000}, // 0  R5 user read, user page
    '{1'b0,1'b1,1'b0,1'b0,2'b01,2'b11,1'b0,1'b1, 2'b10,3'b101}, // 1  R4 second level supervisor
    '{1'b0,1'b1,1'b0,1'b0,2'b10,2'b11,1'b0,1'b1, 2'b10,3'b101}, // 2  R4 first level supervisor
    '{1'b1,1'b1,1'b0,1'b0,2'b11,2'b11,1'b0,1'b1, 2'b00,3'b000}, // 3  R5 user write ok
    '{1'b1,1'b1,1'b0,1'b0,2'b11,2'b01,1'b0,1'b1, 2'b10,3'b111}, // 4  R4 second level read-only
    '{1'b1,1'b1,1'b0,1'b0,2'b11,2'b10,1'b0,1'b1, 2'b10,3'b111}, // 5  R5 first level read-only
    '{1'b0,1'b0,1'b0,1'b1,2'b00,2'b00,1'b0,1'b1, 2'b00,3'b000}, // 6  R6 supervisor read
    '{1'b1,1'b0,1'b0,1'b0,2'b11,2'b01,1'b0,1'b1, 2'b00,3'b000}, // 7  R7 wp off
    '{1'b1,1'b0,1'b0,1'b1,2'b11,2'b01,1'b0,1'b1, 2'b10,3'b011}, // 8  R7 wp on
    '{1'b1,1'b0,1'b0,1'b0,2'b01,2'b00,1'b0,1'b1, 2'b10,3'b011}, // 9  R8 sup page read-only
    '{1'b1,1'b0,1'b0,1'b1,2'b00,2'b11,1'b0,1'b1, 2'b00,3'b000}, // 10 R6 sup write sup rw page
    '{1'b0,1'b1,1'b1,1'b0,2'b00,2'b00,1'b0,1'b1, 2'b00,3'b000}, // 11 R9 forced read
    '{1'b1,1'b1,1'b1,1'b1,2'b11,2'b00,1'b0,1'b1, 2'b10,3'b011}, // 12 R9 forced write wp on
    '{1'b1,1'b1,1'b1,1'b0,2'b11,2'b00,1'b0,1'b1, 2'b00,3'b000}, // 13 R9 forced write wp off
    '{1'b0,1'b1,1'b0,1'b0,2'b00,2'b00,1'b1,1'b1, 2'b01,3'b000}, // 14 R10 seg hides page
    '{1'b1,1'b1,1'b0,1'b0,2'b11,2'b11,1'b0,1'b0, 2'b01,3'b000}, // 15 R11 code segment write
    '{1'b0,1'b1,1'b0,1'b0,2'b11,2'b00,1'b0,1'b0, 2'b00,3'b000}, // 16 R11 read ignores segWritable
    '{1'b0,1'b0,1'b0,1'b0,2'b11,2'b11,1'b1,1'b1, 2'b01,3'b000}  // 17 R10 sup read seg fault
  };

  function automatic string tagOf(int idx);
    case (idx)
      1, 2, 4:     return "R4";
      0, 3, 5:     return "R5";
      6, 10:       return "R6";
      7, 8:        return "R7";
      9:           return "R8";
      11, 12, 13:  return "R9";
      14, 17:      return "R10";
      default:     return "R11";
    endcase
  endfunction

  logic       clk = 1'b0;
  logic       rst;
  logic       reqValid, reqWrite, reqUser, reqForceSup, wpEnable;
  logic [1:0] entUser, entWrite;
  logic       segFault, segWritable;
  logic       rspValid;
  logic [1:0] rspCode;
  logic [2:0] rspErr;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  always #2 clk = ~clk;

  prot_gate #(.LEVELS(2)) dut_i (
    .clk         (clk),
    .rst         (rst),
    .reqValid    (reqValid),
    .reqWrite    (reqWrite),
    .reqUser     (reqUser),
    .reqForceSup (reqForceSup),
    .wpEnable    (wpEnable),
    .entUser     (entUser),
    .entWrite    (entWrite),
    .segFault    (segFault),
    .segWritable (segWritable),
    .rspValid    (rspValid),
    .rspCode     (rspCode),
    .rspErr      (rspErr)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic drive(vec_t v, logic valid);
    reqValid    = valid;
    reqWrite    = v.wr;
    reqUser     = v.usr;
    reqForceSup = v.frc;
    wpEnable    = v.wp;
    entUser     = v.eu;
    entWrite    = v.ew;
    segFault    = v.sf;
    segWritable = v.sw;
  endtask

  task automatic expectResult(string tag, vec_t v);
    check("R1", "rspValid", 32'(rspValid), 32'd1);
    check(tag, "rspCode", 32'(rspCode), 32'(v.code));
    check("R12", {tag, " rspErr"}, 32'(rspErr), 32'(v.err));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    drive(VECS[0], 1'b0);
    repeat (3) @(negedge clk);
    // R2 reset state
    check("R2", "rspValid", 32'(rspValid), 32'd0);
    check("R2", "rspCode", 32'(rspCode), 32'd0);
    check("R2", "rspErr", 32'(rspErr), 32'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i], 1'b1);
      @(negedge clk);
      expectResult(tagOf(i), VECS[i]);
      // idle cycle with disturbing inputs: R1 hold
      drive(VECS[(i + 7) % NV], 1'b0);
      segFault = 1'b1;
      @(negedge clk);
      check("R1", "idle rspValid", 32'(rspValid), 32'd0);
      check("R1", "held rspCode", 32'(rspCode), 32'(VECS[i].code));
      check("R1", "held rspErr", 32'(rspErr), 32'(VECS[i].err));
    end

    // R1 back-to-back requests
    drive(VECS[8], 1'b1);
    @(negedge clk);
    drive(VECS[15], 1'b1);
    expectResult("R7", VECS[8]);
    @(negedge clk);
    expectResult("R11", VECS[15]);
    drive(VECS[0], 1'b0);
    @(negedge clk);
    check("R1", "pulse ends", 32'(rspValid), 32'd0);

    // R2 reset overrides a present request
    drive(VECS[4], 1'b1);
    @(negedge clk);
    expectResult("R5", VECS[4]);
    rst = 1'b1;
    drive(VECS[5], 1'b1);
    @(negedge clk);
    check("R2", "rspValid under reset", 32'(rspValid), 32'd0);
    check("R2", "rspCode under reset", 32'(rspCode), 32'd0);
    check("R2", "rspErr under reset", 32'(rspErr), 32'd0);
    rst = 1'b0;
    drive(VECS[0], 1'b0);
    @(negedge clk);
    // R3 encoding stays legal after recovery
    drive(VECS[14], 1'b1);
    @(negedge clk);
    expectResult("R3", VECS[14]);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule